// File: doc/BRIEF.md
# Clock Synthesizer Program Word Encoder

This block turns a requested pixel clock, given as an unsigned count of 0.01 MHz steps, into the control word for a serially loaded frequency synthesizer. A one-cycle start strobe launches a request. The block first rejects frequencies outside the legal window. It then doubles the request, counting a power-of-two post divider, until the oscillator frequency lies in its operating band. A sequential divider scales the oscillator frequency against the reference to give a rounded feedback count. That count, less a fixed offset, is packed together with the post-divider code and a fixed stop-bit pattern.

The result is a 16-bit word, the post divider as a one-hot value and an error flag. All three are registered and change only on the cycle in which `done_o` pulses. Whatever sits around the block converts a pixel period into the request and shifts the word out serially.

Top module: `clksyn_word_enc`

## Requirements
- R1: A request above 15938 finishes with `err_o`=1, `word_o`=0 and `postdiv_o`=0.
- R2: A request below 1000 finishes with `err_o`=1, `word_o`=0 and `postdiv_o`=0. The limits 1000 and 15938 are themselves accepted.
- R3: An accepted request is doubled until it reaches at least 8000, starting from a post divider of 1. `postdiv_o` reports the final divider as the value 1, 2, 4 or 8.
- R4: The feedback count is floor((floor(f*46*1000/1432) + 500) / 1000), where f is the doubled frequency. This rounds f*46/1432 to the nearest integer.
- R5: `word_o[8:0]` holds the feedback count minus 257.
- R6: `word_o[10:9]` holds the post-divider code: 3 for divider 1, 2 for divider 2, 1 for divider 4 and 0 for divider 8.
- R7: On a valid result `word_o[12:11]` is 2'b11 and `word_o[15:13]` is 0 (stop pattern 0x1800).
- R8: `busy_o` rises in the cycle after an accepted start and falls in the cycle in which `done_o` pulses. `done_o` lasts one cycle. A start seen while `busy_o` is high is ignored.
- R9: `word_o`, `postdiv_o` and `err_o` change only when `done_o` pulses and otherwise hold their values.
- R10: After reset `busy_o`, `done_o` and `err_o` are 0, `word_o` is 0 and `postdiv_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, taken only while idle |
| freq_i | input | 16 | Requested frequency in 0.01 MHz steps |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Last request was out of range |
| word_o | output | 16 | Packed program word |
| postdiv_o | output | 4 | Chosen post divider (1, 2, 4 or 8) |

## Verification
The bench builds the block with its default parameters: a 16-bit request, a 32-bit restoring divider, reference 1432, multiplier 46, rounding scale 1000 and offset 257. With these values every post-divider shift from 0 to 3 can be reached from legal requests. The same holds for a feedback count that rounds up rather than down, both window edges with their first rejected neighbours, and the full 9-bit low field up to 257.

// File: rtl/clksyn_pkg.sv
package clksyn_pkg;

    localparam int WORD_W   = 16;
    localparam int LOW_W    = 9;
    localparam int CODE_LSB = 9;
    localparam int CODE_W   = 2;
    localparam int SHIFT_W  = 2;
    localparam int PDIV_W   = 4;
    localparam logic [WORD_W-1:0] STOP_PATTERN = 16'h1800;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PRESCALE,
        ST_RATIO,
        ST_ROUND
    } enc_state_t;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic [PDIV_W-1:0] postdiv;
        logic              err;
    } enc_result_t;

    // Divider 1,2,4,8 (shift 0..3) maps to codes 3,2,1,0.
    function automatic logic [CODE_W-1:0] div_code(input logic [SHIFT_W-1:0] shift);
        return CODE_W'(2'd3 - shift);
    endfunction

endpackage

// File: rtl/clksyn_prescale.sv
module clksyn_prescale
    import clksyn_pkg::*;
#(
    parameter int          FREQ_W    = 16,
    parameter int unsigned F_MAX     = 15938,
    parameter int unsigned F_MIN     = 1000,
    parameter int unsigned VCO_FLOOR = 8000,
    localparam int         WORK_W    = FREQ_W + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [FREQ_W-1:0]  freq_i,
    output logic               ready_o,
    output logic               err_o,
    output logic [WORK_W-1:0]  work_o,
    output logic [SHIFT_W-1:0] shift_o
);

    localparam logic [WORK_W-1:0] MAX_L   = WORK_W'(F_MAX);
    localparam logic [WORK_W-1:0] MIN_L   = WORK_W'(F_MIN);
    localparam logic [WORK_W-1:0] FLOOR_L = WORK_W'(VCO_FLOOR);

    logic              running;
    logic [WORK_W-1:0] freq_ext;

    assign freq_ext = WORK_W'(freq_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            ready_o <= 1'b0;
            err_o   <= 1'b0;
            work_o  <= '0;
            shift_o <= '0;
        end else begin
            ready_o <= 1'b0;
            if (load) begin
                work_o  <= freq_ext;
                shift_o <= '0;
                if (freq_ext > MAX_L || freq_ext < MIN_L) begin
                    err_o   <= 1'b1;
                    ready_o <= 1'b1;
                    running <= 1'b0;
                end else begin
                    err_o   <= 1'b0;
                    running <= 1'b1;
                end
            end else if (running) begin
                if (work_o < FLOOR_L) begin
                    work_o  <= work_o << 1;
                    shift_o <= shift_o + 1'b1;
                end else begin
                    running <= 1'b0;
                    ready_o <= 1'b1;
                end
            end
        end
    end

    // R3: a good result lies in the oscillator band [floor, 2*floor).
    p_band_r3: assert property (@(posedge clk) disable iff (rst)
        (ready_o && !err_o) |-> (work_o >= FLOOR_L && work_o < (FLOOR_L << 1)));

    // R1: an over-range request is flagged on the next cycle.
    p_reject_high_r1: assert property (@(posedge clk) disable iff (rst)
        (load && freq_ext > MAX_L) |=> (ready_o && err_o));

    // R2: an under-range request is flagged on the next cycle.
    p_reject_low_r2: assert property (@(posedge clk) disable iff (rst)
        (load && freq_ext < MIN_L) |=> (ready_o && err_o));

endmodule

// File: rtl/clksyn_rdiv.sv
module clksyn_rdiv #(
    parameter int W     = 32,
    localparam int CNT_W = $clog2(W + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy_o,
    output logic         valid_o,
    output logic [W-1:0] quot_o
);

    logic [W-1:0]     acc;
    logic [W-1:0]     dvs;
    logic [W:0]       rem;
    logic [W:0]       rem_sh;
    logic [W:0]       sub;
    logic             ge;
    logic [CNT_W-1:0] cnt;

    assign rem_sh = {rem[W-1:0], acc[W-1]};
    assign ge     = rem_sh >= {1'b0, dvs};
    assign sub    = rem_sh - {1'b0, dvs};
    assign quot_o = acc;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc     <= '0;
            dvs     <= '0;
            rem     <= '0;
            cnt     <= '0;
            busy_o  <= 1'b0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (start && !busy_o) begin
                acc    <= dividend;
                dvs    <= divisor;
                rem    <= '0;
                cnt    <= '0;
                busy_o <= 1'b1;
            end else if (busy_o) begin
                rem <= ge ? sub : rem_sh;
                acc <= {acc[W-2:0], ge};
                cnt <= cnt + 1'b1;
                if (cnt == CNT_W'(W - 1)) begin
                    busy_o  <= 1'b0;
                    valid_o <= 1'b1;
                end
            end
        end
    end

    // R4: the partial remainder never reaches the divisor.
    p_rem_bound_r4: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> (rem < {1'b0, dvs}));

    // R8: the controller never restarts a division in flight.
    p_no_restart_r8: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> !start);

endmodule

// File: rtl/clksyn_pack.sv
module clksyn_pack
    import clksyn_pkg::*;
#(
    parameter int          COUNT_W  = 32,
    parameter int unsigned N_OFFSET = 257
) (
    input  logic [COUNT_W-1:0] count_i,
    input  logic [SHIFT_W-1:0] shift_i,
    output logic [WORD_W-1:0]  word_o,
    output logic               fits_o
);

    localparam logic [COUNT_W-1:0] OFF_L = COUNT_W'(N_OFFSET);

    logic [COUNT_W-1:0] diff;
    logic [LOW_W-1:0]   low;
    logic [CODE_W-1:0]  code;

    always_comb begin
        diff   = count_i - OFF_L;
        low    = diff[LOW_W-1:0];
        code   = div_code(shift_i);
        fits_o = (count_i >= OFF_L) && (diff[COUNT_W-1:LOW_W] == '0);
        word_o = STOP_PATTERN
               | (WORD_W'(code) << CODE_LSB)
               | WORD_W'(low);
    end

endmodule

// File: rtl/clksyn_word_enc.sv
module clksyn_word_enc
    import clksyn_pkg::*;
#(
    parameter int          FREQ_W      = 16,
    parameter int unsigned F_MAX       = 15938,
    parameter int unsigned F_MIN       = 1000,
    parameter int unsigned VCO_FLOOR   = 8000,
    parameter int unsigned REF_UNITS   = 1432,
    parameter int unsigned FB_MULT     = 46,
    parameter int unsigned ROUND_SCALE = 1000,
    parameter int unsigned N_OFFSET    = 257,
    parameter int          DIV_W       = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [FREQ_W-1:0] freq_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic [WORD_W-1:0] word_o,
    output logic [PDIV_W-1:0] postdiv_o
);

    localparam int WORK_W = FREQ_W + 1;
    localparam logic [DIV_W-1:0] NUM_K  = DIV_W'(FB_MULT * ROUND_SCALE);
    localparam logic [DIV_W-1:0] REF_L  = DIV_W'(REF_UNITS);
    localparam logic [DIV_W-1:0] SCL_L  = DIV_W'(ROUND_SCALE);
    localparam logic [DIV_W-1:0] HALF_L = DIV_W'(ROUND_SCALE / 2);

    enc_state_t  state;
    enc_result_t res_q;
    logic        done_q;

    logic               pre_load, pre_ready, pre_err;
    logic [WORK_W-1:0]  pre_work;
    logic [SHIFT_W-1:0] pre_shift;

    logic             div_start, div_busy, div_valid;
    logic [DIV_W-1:0] div_dividend, div_divisor, div_quot;

    logic [WORD_W-1:0] packed_word;
    logic              packed_fits;

    clksyn_prescale #(
        .FREQ_W   (FREQ_W),
        .F_MAX    (F_MAX),
        .F_MIN    (F_MIN),
        .VCO_FLOOR(VCO_FLOOR)
    ) u_prescale (
        .clk    (clk),
        .rst    (rst),
        .load   (pre_load),
        .freq_i (freq_i),
        .ready_o(pre_ready),
        .err_o  (pre_err),
        .work_o (pre_work),
        .shift_o(pre_shift)
    );

    clksyn_rdiv #(.W(DIV_W)) u_rdiv (
        .clk     (clk),
        .rst     (rst),
        .start   (div_start),
        .dividend(div_dividend),
        .divisor (div_divisor),
        .busy_o  (div_busy),
        .valid_o (div_valid),
        .quot_o  (div_quot)
    );

    clksyn_pack #(
        .COUNT_W (DIV_W),
        .N_OFFSET(N_OFFSET)
    ) u_pack (
        .count_i(div_quot),
        .shift_i(pre_shift),
        .word_o (packed_word),
        .fits_o (packed_fits)
    );

    // Sequencing: prescale, then ratio division, then rounding division.
    always_comb begin
        pre_load     = 1'b0;
        div_start    = 1'b0;
        div_dividend = '0;
        div_divisor  = '0;
        case (state)
            ST_IDLE: pre_load = start;
            ST_PRESCALE: begin
                if (pre_ready && !pre_err) begin
                    div_start    = 1'b1;
                    div_dividend = DIV_W'(pre_work) * NUM_K;
                    div_divisor  = REF_L;
                end
            end
            ST_RATIO: begin
                if (div_valid) begin
                    div_start    = 1'b1;
                    div_dividend = div_quot + HALF_L;
                    div_divisor  = SCL_L;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            res_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) state <= ST_PRESCALE;
                end
                ST_PRESCALE: begin
                    if (pre_ready) begin
                        if (pre_err) begin
                            res_q  <= '{word: '0, postdiv: '0, err: 1'b1};
                            done_q <= 1'b1;
                            state  <= ST_IDLE;
                        end else begin
                            state <= ST_RATIO;
                        end
                    end
                end
                ST_RATIO: begin
                    if (div_valid) state <= ST_ROUND;
                end
                ST_ROUND: begin
                    if (div_valid) begin
                        res_q  <= '{word: packed_word,
                                    postdiv: PDIV_W'(1) << pre_shift,
                                    err: 1'b0};
                        done_q <= 1'b1;
                        state  <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy_o    = (state != ST_IDLE);
    assign done_o    = done_q;
    assign err_o     = res_q.err;
    assign word_o    = res_q.word;
    assign postdiv_o = res_q.postdiv;

    // R8: completion lasts one cycle.
    p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R8: completion coincides with the fall of busy.
    p_done_ends_busy_r8: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!busy_o && $past(busy_o)));

    // R8: the divider only runs inside a request.
    p_div_inside_r8: assert property (@(posedge clk) disable iff (rst)
        div_busy |-> busy_o);

    // R9: results hold between completions.
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> ($stable(word_o) && $stable(postdiv_o) && $stable(err_o)));

    // R1: a rejected request leaves an empty word.
    p_err_empty_r1: assert property (@(posedge clk) disable iff (rst)
        err_o |-> (word_o == '0 && postdiv_o == '0));

    // R7: a valid word carries the stop pattern.
    p_stop_r7: assert property (@(posedge clk) disable iff (rst)
        (done_o && !err_o) |-> (word_o[12:11] == 2'b11 && word_o[15:13] == 3'b000));

    // R3: the reported divider is a single power of two.
    p_postdiv_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(postdiv_o));

    // R5: the offset count fits its field when a word is taken.
    p_fits_r5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ROUND && div_valid) |-> packed_fits);

endmodule

// File: tb/test_clksyn_word_enc.sv
`timescale 1ns/1ps
module test_clksyn_word_enc;

    localparam int NV = 14;
    localparam logic [15:0] V_FREQ [NV] = '{
        16'd8000, 16'd15938, 16'd1000, 16'd4000, 16'd7999, 16'd2000, 16'd10000,
        16'd12000, 16'd13000, 16'd6500, 16'd15939, 16'd999, 16'd0, 16'd65535};
    localparam logic [15:0] V_WORD [NV] = '{
        16'h1E00, 16'h1EFF, 16'h1800, 16'h1C00, 16'h1D01, 16'h1A00, 16'h1E40,
        16'h1E80, 16'h1EA1, 16'h1CA1, 16'h0000, 16'h0000, 16'h0000, 16'h0000};
    localparam logic [3:0] V_PDIV [NV] = '{
        4'd1, 4'd1, 4'd8, 4'd2, 4'd2, 4'd4, 4'd1,
        4'd1, 4'd1, 4'd2, 4'd0, 4'd0, 4'd0, 4'd0};
    localparam logic V_ERR [NV] = '{
        1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
        1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] freq_i = '0;
    logic        busy_o, done_o, err_o;
    logic [15:0] word_o;
    logic [3:0]  postdiv_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    clksyn_word_enc i_clksyn_word_enc (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .freq_i   (freq_i),
        .busy_o   (busy_o),
        .done_o   (done_o),
        .err_o    (err_o),
        .word_o   (word_o),
        .postdiv_o(postdiv_o)
    );

    task automatic chk(input bit ok, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    task automatic pulse_start(input logic [15:0] f);
        @(negedge clk);
        start  = 1'b1;
        freq_i = f;
        @(negedge clk);
        start  = 1'b0;
    endtask

    task automatic wait_done(output bit seen);
        seen = 0;
        for (int c = 0; c < 400 && !seen; c++) begin
            if (done_o) seen = 1;
            else @(negedge clk);
        end
        chk(seen, "R8 done pulse seen", 32'(seen), 32'd1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        bit seen;
        logic [15:0] held;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: reset state
        chk(!busy_o && !done_o && !err_o, "R10 flags after reset",
            {29'd0, busy_o, done_o, err_o}, 32'd0);
        chk(word_o == 16'h0 && postdiv_o == 4'h0, "R10 word/postdiv after reset",
            {12'd0, postdiv_o, word_o}, 32'd0);

        // R8: busy rises in the cycle after the accepted start
        @(negedge clk);
        start = 1'b1; freq_i = 16'd8000;
        @(negedge clk);
        start = 1'b0;
        chk(busy_o, "R8 busy after start", 32'(busy_o), 32'd1);
        // R8: a start while busy is ignored (would be an error request)
        repeat (4) @(negedge clk);
        start = 1'b1; freq_i = 16'd15939;
        @(negedge clk);
        start = 1'b0;
        wait_done(seen);
        chk(!busy_o, "R8 busy low with done", 32'(busy_o), 32'd0);
        chk(word_o == 16'h1E00 && !err_o, "R8 start while busy ignored",
            {15'd0, err_o, word_o}, 32'h1E00);
        held = word_o;
        @(negedge clk);
        chk(!done_o, "R8 done single cycle", 32'(done_o), 32'd0);
        // R9: outputs stable and no spurious completion
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (done_o || word_o != held || busy_o) begin
                chk(0, "R9 hold between requests", {15'd0, done_o, word_o}, {16'd0, held});
                break;
            end
        end
        chk(word_o == held && postdiv_o == 4'd1, "R9 held word/postdiv",
            {12'd0, postdiv_o, word_o}, {12'd0, 4'd1, held});

        // Vector table: R1 R2 R3 R4 R5 R6 R7
        for (int v = 0; v < NV; v++) begin
            pulse_start(V_FREQ[v]);
            wait_done(seen);
            chk(word_o == V_WORD[v], V_ERR[v] ? "R1/R2 word cleared on reject"
                                              : "R4/R5/R6/R7 packed word",
                32'(word_o), 32'(V_WORD[v]));
            chk(postdiv_o == V_PDIV[v], "R3 post divider",
                32'(postdiv_o), 32'(V_PDIV[v]));
            chk(err_o == V_ERR[v], "R1/R2 range flag",
                32'(err_o), 32'(V_ERR[v]));
        end

        // R9: a rejected request clears the word; a later valid one restores it
        pulse_start(16'd13000);
        wait_done(seen);
        chk(word_o == 16'h1EA1 && !err_o, "R4 round-up after reject",
            {15'd0, err_o, word_o}, 32'h1EA1);

        // R10: reset mid-request returns to the reset state
        pulse_start(16'd2000);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk(!busy_o && word_o == 16'h0 && postdiv_o == 4'h0, "R10 reset mid-request",
            {11'd0, busy_o, postdiv_o, word_o}, 32'd0);

        report();
    end

endmodule